// File: doc/BRIEF.md
# Buck Gate-Drive PWM Generator with Dead Time

This block turns a duty-cycle command into the two gate-enable signals of one synchronous buck stage: a high-side enable and a low-side enable that never overlap. Every timing quantity is counted in steps. One step is one clock of the fine timing clock, which stands for one sixteenth of the master oscillator period. The switching period is programmable, so each channel can run at its own frequency. Each period opens with a rise dead time in which both switches are off. The high side is then on for the commanded on-time. A fall dead time follows with both switches off, and the low side is on for the rest of the period.

The 17-bit duty word is a fraction of the period. The on-time it yields is clamped between a programmable minimum and a programmable maximum. All timing inputs are captured only when a period starts, so a control loop may update them at any time. In continuous mode the periods follow each other without a gap. In single-shot mode, used at light load, each trigger runs one period and both switches then stay off, so inductor current cannot reverse through the low side. An end-of-cycle strobe marks the last step of every period.

Top module: `dpwm_deadtime`

## Requirements
- R1: `gh_o` and `gl_o` are never high in the same step.
- R2: In continuous mode (`single_i`=0), each period lasts max(P,1) steps, where P is the captured `period_i`. The next period follows with no gap, and `eoc_o` is high only during the last step of each period.
- R3: Within a period, counting steps from 0, both outputs are low for dr steps. `gh_o` is then high for ton steps. Both outputs are low for the next df steps, and `gl_o` is high from step dr+ton+df to the end of the period. dr comes from `dt_rise_i`, df from `dt_fall_i`, and ton from R4 and R5.
- R4: The unclamped on-time is floor(`duty_i` × P / 2^17) steps.
- R5: The on-time is first limited to at most `ton_max_i` and then raised to at least `ton_min_i`. When the minimum exceeds the maximum, the minimum wins.
- R6: `period_i`, `duty_i`, `ton_min_i`, `ton_max_i`, `dt_rise_i` and `dt_fall_i` are captured only in the step where a period starts. Changes during a period do not alter that period.
- R7: In single-shot mode (`single_i`=1), both outputs stay low while idle. A high `trigger_i` at a clock edge while idle starts a period at step 0 on that edge. After the last step the block is idle again with both outputs low, and a trigger that arrives during a period is ignored.
- R8: While `rst_ni` is low, all outputs are low immediately. A high `srst_i` at a clock edge forces all outputs low and makes the block idle. In continuous mode, the first edge after reset is released starts a period at step 0.
- R9: A dead-time value of 0 acts as 1 step, so neither gate output rises in the step right after the other one was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fine timing clock, one step per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous reset, active high |
| single_i | input | 1 | 0 = continuous mode, 1 = single-shot mode |
| trigger_i | input | 1 | Starts one period in single-shot mode |
| period_i | input | CNT_W | Period length in steps |
| duty_i | input | DUTY_W | Duty fraction of the period, scaled by 2^17 |
| ton_min_i | input | CNT_W | Minimum on-time in steps |
| ton_max_i | input | CNT_W | Maximum on-time in steps |
| dt_rise_i | input | DT_W | Dead time before the high side turns on |
| dt_fall_i | input | DT_W | Dead time before the low side turns on |
| gh_o | output | 1 | High-side gate enable |
| gl_o | output | 1 | Low-side gate enable |
| eoc_o | output | 1 | High during the last step of a period |

## Verification
The bench compares every step of the outputs against a step-by-step expectation built from the period, the clamped on-time and the two dead times. It drives duty words that fall below the minimum, above the maximum, and into a window where the limits cross. A design with the clamp order reversed would give the maximum where the minimum is due, and one that scaled the duty wrongly would move the high-to-low handoff. The bench rewrites every timing input in the middle of a period. A design that does not hold its captured values would change width in the middle of the period. Zero dead times are driven to expose a direct handoff between the two switches. In single-shot mode, triggers are sent while a period is running. A design that honoured such a trigger, or kept the low side on after the last step, would show extra pulses where the bench expects both outputs off.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  typedef enum logic {MODE_CONT = 1'b0, MODE_SINGLE = 1'b1} dpwm_mode_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} dpwm_state_e;
endpackage

// File: rtl/dpwm_ontime.sv
module dpwm_ontime #(
  parameter int CNT_W  = 12,
  parameter int DUTY_W = 17
) (
  input  logic [CNT_W-1:0]  period_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [CNT_W-1:0]  ton_min_i,
  input  logic [CNT_W-1:0]  ton_max_i,
  output logic [CNT_W-1:0]  ton_o
);
  localparam int PROD_W = CNT_W + DUTY_W;

  logic [PROD_W-1:0] prod;
  logic [CNT_W-1:0]  raw, capped;

  assign prod   = PROD_W'(duty_i) * PROD_W'(period_i);
  assign raw    = prod[PROD_W-1:DUTY_W];
  // cap first, then floor: minimum wins when limits cross
  assign capped = (raw > ton_max_i) ? ton_max_i : raw;
  assign ton_o  = (capped < ton_min_i) ? ton_min_i : capped;
endmodule

// File: rtl/dpwm_timebase.sv
module dpwm_timebase import dpwm_pkg::*; #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             single_i,
  input  logic             trigger_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             run_o,
  output logic             start_o,
  output logic             last_o,
  output logic [CNT_W-1:0] cnt_o
);
  dpwm_state_e      state_q;
  dpwm_mode_e       mode;
  logic [CNT_W-1:0] cnt_q, per_q;
  logic             running;

  assign mode    = dpwm_mode_e'(single_i);
  assign running = (state_q == ST_RUN);
  assign last_o  = running && (({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, per_q});
  assign start_o = !srst_i && (running ? (last_o && mode == MODE_CONT)
                                       : (mode == MODE_CONT || trigger_i));
  assign run_o   = running;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      per_q   <= '0;
    end else if (srst_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (start_o) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      per_q   <= period_i;
    end else if (last_o) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (running) begin
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/dpwm_gate.sv
module dpwm_gate #(
  parameter int CNT_W = 12,
  parameter int DT_W  = 6
) (
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] ton_i,
  input  logic [DT_W-1:0]  dt_rise_i,
  input  logic [DT_W-1:0]  dt_fall_i,
  output logic             gh_o,
  output logic             gl_o
);
  localparam int SUM_W = CNT_W + DT_W + 2;

  logic [SUM_W-1:0] pos, hs_on, hs_off, ls_on;

  assign pos    = SUM_W'(cnt_i);
  assign hs_on  = SUM_W'(dt_rise_i);
  assign hs_off = hs_on + SUM_W'(ton_i);
  assign ls_on  = hs_off + SUM_W'(dt_fall_i);

  assign gh_o = run_i && (pos >= hs_on) && (pos < hs_off);
  assign gl_o = run_i && (pos >= ls_on);
endmodule

// File: rtl/dpwm_deadtime.sv
module dpwm_deadtime #(
  parameter int CNT_W  = 12,
  parameter int DUTY_W = 17,
  parameter int DT_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              single_i,
  input  logic              trigger_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [CNT_W-1:0]  ton_min_i,
  input  logic [CNT_W-1:0]  ton_max_i,
  input  logic [DT_W-1:0]   dt_rise_i,
  input  logic [DT_W-1:0]   dt_fall_i,
  output logic              gh_o,
  output logic              gl_o,
  output logic              eoc_o
);
  logic             run, start, last;
  logic [CNT_W-1:0] cnt, ton_calc, ton_q;
  logic [DT_W-1:0]  dtr_eff, dtf_eff, dtr_q, dtf_q;

  dpwm_ontime #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_ontime (
    .period_i (period_i),
    .duty_i   (duty_i),
    .ton_min_i(ton_min_i),
    .ton_max_i(ton_max_i),
    .ton_o    (ton_calc)
  );

  dpwm_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .srst_i   (srst_i),
    .single_i (single_i),
    .trigger_i(trigger_i),
    .period_i (period_i),
    .run_o    (run),
    .start_o  (start),
    .last_o   (last),
    .cnt_o    (cnt)
  );

  // zero dead time is raised to one step
  assign dtr_eff = (dt_rise_i == '0) ? DT_W'(1) : dt_rise_i;
  assign dtf_eff = (dt_fall_i == '0) ? DT_W'(1) : dt_fall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ton_q <= '0;
      dtr_q <= DT_W'(1);
      dtf_q <= DT_W'(1);
    end else if (start) begin
      ton_q <= ton_calc;
      dtr_q <= dtr_eff;
      dtf_q <= dtf_eff;
    end
  end

  dpwm_gate #(.CNT_W(CNT_W), .DT_W(DT_W)) u_gate (
    .run_i    (run),
    .cnt_i    (cnt),
    .ton_i    (ton_q),
    .dt_rise_i(dtr_q),
    .dt_fall_i(dtf_q),
    .gh_o     (gh_o),
    .gl_o     (gl_o)
  );

  assign eoc_o = last;
endmodule

// File: rtl/dpwm_deadtime_chk.sv
module dpwm_deadtime_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic srst_i,
  input logic single_i,
  input logic gh_o,
  input logic gl_o,
  input logic eoc_o
);
  // R1
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gh_o && gl_o));

  // R9
  gh_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gh_o) |-> !$past(gl_o));

  // R9
  gl_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gl_o) |-> !$past(gh_o));

  // R7
  single_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc_o && single_i) |=> (!gh_o && !gl_o && !eoc_o));

  // R8
  sync_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (!gh_o && !gl_o && !eoc_o));
endmodule

bind dpwm_deadtime dpwm_deadtime_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .srst_i  (srst_i),
  .single_i(single_i),
  .gh_o    (gh_o),
  .gl_o    (gl_o),
  .eoc_o   (eoc_o)
);

// File: tb/dpwm_deadtime_tb.sv
module dpwm_deadtime_tb;
  localparam int CNT_W  = 12;
  localparam int DUTY_W = 17;
  localparam int DT_W   = 6;

  typedef struct {
    logic  gh;
    logic  gl;
    logic  eoc;
    string tag;
    int    step;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, srst_i = 1'b1, single_i = 1'b0, trigger_i = 1'b0;
  logic [CNT_W-1:0]  period_i = '0, ton_min_i = '0, ton_max_i = '0;
  logic [DUTY_W-1:0] duty_i = '0;
  logic [DT_W-1:0]   dt_rise_i = '0, dt_fall_i = '0;
  logic gh_o, gl_o, eoc_o;

  int checks = 0;
  int errors = 0;
  item_t exp_q[$];

  always #2 clk = ~clk;

  dpwm_deadtime #(.CNT_W(CNT_W), .DUTY_W(DUTY_W), .DT_W(DT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .srst_i(srst_i), .single_i(single_i),
    .trigger_i(trigger_i), .period_i(period_i), .duty_i(duty_i),
    .ton_min_i(ton_min_i), .ton_max_i(ton_max_i), .dt_rise_i(dt_rise_i),
    .dt_fall_i(dt_fall_i), .gh_o(gh_o), .gl_o(gl_o), .eoc_o(eoc_o)
  );

  // monitor: one expected item per step
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      checks++;
      if ({gh_o, gl_o, eoc_o} !== {it.gh, it.gl, it.eoc}) begin
        errors++;
        $display("FAIL %s step %0d gh/gl/eoc actual %b%b%b expected %b%b%b",
                 it.tag, it.step, gh_o, gl_o, eoc_o, it.gh, it.gl, it.eoc);
      end
    end
  end

  task automatic chk(input logic [2:0] act, input logic [2:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s gh/gl/eoc actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic push_idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it = '{gh: 1'b0, gl: 1'b0, eoc: 1'b0, tag: tag, step: i};
      exp_q.push_back(it);
    end
  endtask

  // expected pattern of one period from R2..R5, R9
  task automatic push_period(input int p, input int duty, input int tmin, input int tmax,
                             input int dr, input int df, input string tag);
    longint prod;
    int raw, ton, len, rdr, rdf;
    prod = longint'(duty) * longint'(p);
    raw  = int'(prod >> DUTY_W);
    ton  = (raw > tmax) ? tmax : raw;
    ton  = (ton < tmin) ? tmin : ton;
    rdr  = (dr == 0) ? 1 : dr;
    rdf  = (df == 0) ? 1 : df;
    len  = (p < 1) ? 1 : p;
    for (int c = 0; c < len; c++) begin
      item_t it;
      it.gh   = (c >= rdr) && (c < rdr + ton);
      it.gl   = (c >= rdr + ton + rdf);
      it.eoc  = (c == len - 1);
      it.tag  = tag;
      it.step = c;
      exp_q.push_back(it);
    end
  endtask

  task automatic set_in(input int p, input int duty, input int tmin, input int tmax,
                        input int dr, input int df);
    period_i  = CNT_W'(p);
    duty_i    = DUTY_W'(duty);
    ton_min_i = CNT_W'(tmin);
    ton_max_i = CNT_W'(tmax);
    dt_rise_i = DT_W'(dr);
    dt_fall_i = DT_W'(df);
  endtask

  // continuous: apply inputs, queue the period, wait until it has started
  task automatic run_period(input int p, input int duty, input int tmin, input int tmax,
                            input int dr, input int df, input string tag, input bit glitch);
    set_in(p, duty, tmin, tmax, dr, df);
    push_period(p, duty, tmin, tmax, dr, df, tag);
    while (exp_q.size() >= p) @(posedge clk);
    #1;
    if (glitch) begin
      // R6: scramble all inputs inside the period
      set_in(p + 7, duty ^ 17'h1ffff, 0, 4000, 9, 9);
      repeat (3) @(posedge clk);
      #1;
    end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    set_in(40, 65536, 2, 30, 3, 4);
    #1;
    chk({gh_o, gl_o, eoc_o}, 3'b000, "R8 async reset");
    @(posedge clk); #1;
    rst_ni = 1'b1;
    @(posedge clk); #1;
    chk({gh_o, gl_o, eoc_o}, 3'b000, "R8 sync reset held");
    srst_i = 1'b0;
    @(posedge clk); #1;
    // continuous mode periods
    run_period(40, 65536,  2, 30, 3, 4, "R3 R4 half duty", 1'b0);
    run_period(40, 4000,   5, 30, 3, 4, "R5 R6 below min", 1'b1);
    run_period(40, 131071, 2, 30, 3, 4, "R5 above max", 1'b0);
    run_period(40, 65536, 12,  8, 2, 2, "R5 crossed limits", 1'b0);
    run_period(25, 65536,  2, 30, 0, 0, "R9 zero dead time", 1'b0);
    run_period(17, 98304,  2, 30, 2, 2, "R2 short period", 1'b1);
    run_period(30, 43690,  1, 40, 5, 1, "R2 R4 third duty", 1'b0);
    drain();
    srst_i   = 1'b1;
    single_i = 1'b1;
    @(posedge clk); #1;
    chk({gh_o, gl_o, eoc_o}, 3'b000, "R8 sync reset in run");
    srst_i = 1'b0;
    // single-shot idle
    push_idle(6, "R7 idle before trigger");
    drain();
    set_in(20, 65536, 2, 30, 2, 3);
    trigger_i = 1'b1;
    @(posedge clk); #1;
    trigger_i = 1'b0;
    push_period(20, 65536, 2, 30, 2, 3, "R7 single shot");
    push_idle(8, "R7 idle after shot");
    repeat (6) @(posedge clk);
    #1;
    trigger_i = 1'b1;   // ignored while running
    @(posedge clk); #1;
    trigger_i = 1'b0;
    drain();
    // second shot, cut by asynchronous reset
    set_in(20, 65536, 2, 30, 2, 3);
    trigger_i = 1'b1;
    @(posedge clk); #1;
    trigger_i = 1'b0;
    push_period(20, 65536, 2, 30, 2, 3, "R7 second shot");
    while (exp_q.size() > 15) @(posedge clk);
    #1;
    exp_q.delete();
    rst_ni = 1'b0;
    #0.5;
    chk({gh_o, gl_o, eoc_o}, 3'b000, "R8 async reset mid period");
    @(posedge clk); #1;
    rst_ni = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk({gh_o, gl_o, eoc_o}, 3'b000, "R7 idle after reset");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule